// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

The block walks a linked ring of 16-byte descriptors that sit in a small word-addressed memory. Software writes descriptors through a plain memory port, loads a 36-bit start address and issues start, stop and resume commands. The engine fetches the four words of a descriptor and checks the ownership bit and, when enabled, the byte checksum. It models the data movement with a fixed-latency stub, writes back the transferred length and hands ownership back. It then follows the next pointer.

The queue is a transmit queue by default. A zero-length descriptor without the bypass flag is reported as a length error, and the engine holds on it. Software can then mark it as bypassed, fix the checksum and resume. Three interrupt sources (done, checksum error, length error) are latched as write-one-to-clear status bits and gated by an enable mask onto one interrupt line.

Top module: `dq_ring_engine`

## Requirements
- R1: After reset the engine is inactive, the current address is 0, and all interrupt status bits and the interrupt line are 0.
- R2: A start command while inactive loads the current address from the start address and sets the active flag. A start while active is ignored and leaves the current address unchanged.
- R3: The engine processes a descriptor only when bit 0 (hardware owned) of word 0 is 1. Otherwise it stays active and holds with the current address on that descriptor until a resume command refetches it.
- R4: Descriptor layout. Word 0 = {length[31:16], checksum[15:8], flags[7:0]}. Word 1 = next address bits 31:0. Word 2 = buffer address bits 31:0. Word 3 = {actual length[31:16], reserved[15:8], extension[7:0]}. Extension bits 7:4 give next-address bits 35:32 and bits 3:0 give buffer-address bits 35:32. Word k of a descriptor at byte address A sits at memory word A[IW+1:2]+k.
- R5: The checksum passes when the sum modulo 256 of all 16 descriptor bytes is 0xFF. With checking enabled, a failing owned descriptor sets status bit 1. The engine then holds on that descriptor without writing to it.
- R6: On completion the engine writes the actual length to word 3 bits 31:16 and keeps word 3 bits 15:0. It clears bit 0 of word 0 and leaves the other bits unchanged. Status bit 0 (done) is set only when flag bit 7 is 1.
- R7: After completion the current address becomes the 36-bit next address, and the engine fetches the descriptor there.
- R8: With flag bit 2 (bypass) set, the descriptor completes with actual length 0, whatever its length field holds.
- R9: On a transmit queue, an owned descriptor with length 0 and no bypass sets status bit 2. The engine holds on it with no write-back until resumed.
- R10: A stop command clears the active flag at the next clock edge. No descriptor write happens in or after the stop cycle.
- R11: Each status bit is cleared only by writing 1 to its clear input. The interrupt line is high exactly when a status bit and its enable bit are both 1.
- R12: A resume while inactive sets the active flag and fetches at the current address, without reloading the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_addr_i | input | 36 | Ring start byte address |
| cmd_start_i | input | 1 | Start command pulse |
| cmd_stop_i | input | 1 | Stop command pulse |
| cmd_resume_i | input | 1 | Resume command pulse |
| csum_en_i | input | 1 | Enable descriptor checksum check |
| irq_en_i | input | 3 | Interrupt enable mask |
| irq_clr_i | input | 3 | Write-one-to-clear for status bits |
| sw_we_i | input | 1 | Software memory write enable |
| sw_waddr_i | input | IW | Software write word index |
| sw_wdata_i | input | 32 | Software write data |
| sw_raddr_i | input | IW | Software read word index |
| sw_rdata_o | output | 32 | Software read data |
| cur_addr_o | output | 36 | Current descriptor byte address |
| active_o | output | 1 | Queue active flag |
| irq_status_o | output | 3 | Status: bit 0 done, bit 1 checksum error, bit 2 length error |
| irq_o | output | 1 | Masked interrupt line |

## Verification
The hardest state to reach is a stop that lands while a descriptor is mid-transfer. The bench arms an owned descriptor, resumes, and counts clock cycles so that the stop arrives inside the latency window before write-back. It then reads the descriptor back to show that ownership and the actual length are untouched. The 36-bit pointer path is also hard to reach, because the memory only decodes low address bits. The bench links a descriptor whose extension nibble points above 4 GiB, which aliases onto an already released descriptor, and checks the upper bits of the held current address.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_XFER, ST_WB_LEN, ST_WB_OWN, ST_PARK
  } dq_state_e;

  localparam int FLAG_OWN    = 0;
  localparam int FLAG_BYPASS = 2;
  localparam int FLAG_IOC    = 7;

  localparam int IRQ_NUM    = 3;
  localparam int IRQ_DONE   = 0;
  localparam int IRQ_CSERR  = 1;
  localparam int IRQ_LENERR = 2;

  localparam int DESC_WORDS = 4;
  localparam int ADDR_W     = 36;
endpackage

// File: rtl/dq_mem.sv
module dq_mem #(
  parameter int WORDS = 64,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          eng_we_i,
  input  logic [IW-1:0] eng_waddr_i,
  input  logic [31:0]   eng_wdata_i,
  input  logic [IW-1:0] eng_raddr_i,
  output logic [31:0]   eng_rdata_o,
  input  logic          sw_we_i,
  input  logic [IW-1:0] sw_waddr_i,
  input  logic [31:0]   sw_wdata_i,
  input  logic [IW-1:0] sw_raddr_i,
  output logic [31:0]   sw_rdata_o
);
  logic [31:0] mem_q [WORDS];

  // engine write wins a same-cycle collision
  always_ff @(posedge clk_i) begin
    if (eng_we_i)     mem_q[eng_waddr_i] <= eng_wdata_i;
    else if (sw_we_i) mem_q[sw_waddr_i]  <= sw_wdata_i;
  end

  assign eng_rdata_o = mem_q[eng_raddr_i];
  assign sw_rdata_o  = mem_q[sw_raddr_i];
endmodule

// File: rtl/dq_csum.sv
module dq_csum #(
  parameter int NWORDS = 4
) (
  input  logic [31:0] words_i [NWORDS],
  output logic        ok_o
);
  logic [7:0] sum;
  always_comb begin
    sum = '0;
    for (int w = 0; w < NWORDS; w++)
      for (int b = 0; b < 4; b++)
        sum = sum + words_i[w][8*b +: 8];
  end
  assign ok_o = (sum == 8'hFF);
endmodule

// File: rtl/dq_irq.sv
module dq_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] status_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & en_i);

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_w1c_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_q[i]) |-> $past(clr_i[i]));
  end
endmodule

// File: rtl/dq_ring_engine.sv
module dq_ring_engine
  import dq_pkg::*;
#(
  parameter int  MEM_WORDS   = 64,
  parameter int  XFER_CYCLES = 4,
  parameter bit  IS_TX       = 1'b1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [35:0]                  start_addr_i,
  input  logic                         cmd_start_i,
  input  logic                         cmd_stop_i,
  input  logic                         cmd_resume_i,
  input  logic                         csum_en_i,
  input  logic [2:0]                   irq_en_i,
  input  logic [2:0]                   irq_clr_i,
  input  logic                         sw_we_i,
  input  logic [$clog2(MEM_WORDS)-1:0] sw_waddr_i,
  input  logic [31:0]                  sw_wdata_i,
  input  logic [$clog2(MEM_WORDS)-1:0] sw_raddr_i,
  output logic [31:0]                  sw_rdata_o,
  output logic [35:0]                  cur_addr_o,
  output logic                         active_o,
  output logic [2:0]                   irq_status_o,
  output logic                         irq_o
);
  localparam int IW = $clog2(MEM_WORDS);
  localparam int LW = $clog2(XFER_CYCLES + 1);

  dq_state_e        state_q;
  logic [1:0]       cnt_q;
  logic [LW-1:0]    lat_q;
  logic [ADDR_W-1:0] cur_q;
  logic [15:0]      act_len_q;
  logic [31:0]      desc_q [DESC_WORDS];

  logic [IW-1:0]    base_idx, rd_idx;
  logic [31:0]      rd_data;
  logic             eng_we;
  logic [IW-1:0]    eng_waddr;
  logic [31:0]      eng_wdata;
  logic             csum_ok;
  logic [IRQ_NUM-1:0] irq_set;

  logic        own, bypass, ioc;
  logic [15:0] len;
  logic [35:0] next_addr;

  assign base_idx  = cur_q[IW+1:2];
  assign rd_idx    = base_idx + IW'(cnt_q);
  assign own       = desc_q[0][FLAG_OWN];
  assign bypass    = desc_q[0][FLAG_BYPASS];
  assign ioc       = desc_q[0][FLAG_IOC];
  assign len       = desc_q[0][31:16];
  assign next_addr = {desc_q[3][7:4], desc_q[1]};

  logic cs_fail, len_fail;
  assign cs_fail  = own && csum_en_i && !csum_ok;
  assign len_fail = own && !cs_fail && !bypass && IS_TX && (len == 16'd0);

  dq_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk_i       (clk_i),
    .eng_we_i    (eng_we),
    .eng_waddr_i (eng_waddr),
    .eng_wdata_i (eng_wdata),
    .eng_raddr_i (rd_idx),
    .eng_rdata_o (rd_data),
    .sw_we_i     (sw_we_i),
    .sw_waddr_i  (sw_waddr_i),
    .sw_wdata_i  (sw_wdata_i),
    .sw_raddr_i  (sw_raddr_i),
    .sw_rdata_o  (sw_rdata_o)
  );

  dq_csum #(.NWORDS(DESC_WORDS)) u_csum (
    .words_i (desc_q),
    .ok_o    (csum_ok)
  );

  always_comb begin
    irq_set = '0;
    if (!cmd_stop_i) begin
      irq_set[IRQ_CSERR]  = (state_q == ST_CHECK) && cs_fail;
      irq_set[IRQ_LENERR] = (state_q == ST_CHECK) && len_fail;
      irq_set[IRQ_DONE]   = (state_q == ST_WB_OWN) && ioc;
    end
  end

  dq_irq #(.N(IRQ_NUM)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (irq_set),
    .clr_i    (irq_clr_i),
    .en_i     (irq_en_i),
    .status_o (irq_status_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    eng_we    = 1'b0;
    eng_waddr = base_idx;
    eng_wdata = '0;
    if (!cmd_stop_i) begin
      if (state_q == ST_WB_LEN) begin
        eng_we    = 1'b1;
        eng_waddr = base_idx + IW'(3);
        eng_wdata = {act_len_q, desc_q[3][15:0]};
      end else if (state_q == ST_WB_OWN) begin
        eng_we    = 1'b1;
        eng_wdata = desc_q[0] & ~(32'd1 << FLAG_OWN);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      lat_q     <= '0;
      cur_q     <= '0;
      act_len_q <= '0;
      for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
    end else if (cmd_stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (cmd_start_i) begin
            cur_q   <= start_addr_i;
            state_q <= ST_FETCH;
          end else if (cmd_resume_i) begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          desc_q[cnt_q] <= rd_data;
          cnt_q         <= cnt_q + 2'd1;
          if (cnt_q == 2'd3) state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          lat_q <= '0;
          if (!own || cs_fail || len_fail) begin
            state_q <= ST_PARK;
          end else if (bypass) begin
            act_len_q <= 16'd0;
            state_q   <= ST_WB_LEN;
          end else begin
            act_len_q <= len;
            state_q   <= ST_XFER;
          end
        end
        ST_XFER: begin
          lat_q <= lat_q + LW'(1);
          if (lat_q == LW'(XFER_CYCLES - 1)) state_q <= ST_WB_LEN;
        end
        ST_WB_LEN: state_q <= ST_WB_OWN;
        ST_WB_OWN: begin
          cur_q   <= next_addr;
          cnt_q   <= '0;
          state_q <= ST_FETCH;
        end
        ST_PARK: begin
          cnt_q <= '0;
          if (cmd_resume_i) state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_addr_o = cur_q;
  assign active_o   = (state_q != ST_IDLE);

  assert_stop_clears_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stop_i |=> !active_o);

  assert_start_loads_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && cmd_start_i && !cmd_stop_i) |=> (active_o && cur_addr_o == $past(start_addr_i)));

  assert_resume_keeps_addr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && cmd_resume_i && !cmd_start_i && !cmd_stop_i) |=> (active_o && $stable(cur_addr_o)));

  assert_park_holds_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARK) |=> $stable(cur_addr_o));

  assert_no_write_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we |-> (active_o && !cmd_stop_i));
endmodule

// File: tb/sim_dq_ring_engine.sv
module sim_dq_ring_engine;
  localparam int MW = 64;
  localparam int IW = $clog2(MW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [35:0]   start_addr = '0;
  logic          c_start = 0, c_stop = 0, c_resume = 0, cs_en = 0;
  logic [2:0]    irq_en = '0, irq_clr = '0;
  logic          sw_we = 0;
  logic [IW-1:0] sw_waddr = '0, sw_raddr = '0;
  logic [31:0]   sw_wdata = '0, sw_rdata;
  logic [35:0]   cur_addr;
  logic          active, irq;
  logic [2:0]    status;

  dq_ring_engine #(.MEM_WORDS(MW), .XFER_CYCLES(4), .IS_TX(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_addr_i(start_addr),
    .cmd_start_i(c_start), .cmd_stop_i(c_stop), .cmd_resume_i(c_resume),
    .csum_en_i(cs_en), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .sw_we_i(sw_we), .sw_waddr_i(sw_waddr), .sw_wdata_i(sw_wdata),
    .sw_raddr_i(sw_raddr), .sw_rdata_o(sw_rdata),
    .cur_addr_o(cur_addr), .active_o(active),
    .irq_status_o(status), .irq_o(irq)
  );

  int vectors = 0, fails = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired actual=%0d expected<=100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] bsum(input logic [31:0] w);
    return w[7:0] + w[15:8] + w[23:16] + w[31:24];
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    sw_we = 1; sw_waddr = IW'(idx); sw_wdata = d;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    sw_raddr = IW'(idx);
    #1 d = sw_rdata;
  endtask

  // descriptor at byte address 16*slot, word 4*slot
  task automatic put_desc(input int slot, input logic [15:0] len, input logic [7:0] flags,
                          input logic [35:0] nxt, input logic [31:0] buf_lo, input bit bad);
    logic [31:0] w0, w1, w2, w3;
    logic [7:0] cs;
    w1 = nxt[31:0];
    w2 = buf_lo;
    w3 = {16'h0, 8'h00, nxt[35:32], 4'h3};
    w0 = {len, 8'h00, flags};
    cs = 8'hFF - (bsum(w0) + bsum(w1) + bsum(w2) + bsum(w3));
    if (bad) cs = cs ^ 8'h5A;
    w0[15:8] = cs;
    wr(4*slot, w0); wr(4*slot+1, w1); wr(4*slot+2, w2); wr(4*slot+3, w3);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: c_start = 1;
      1: c_stop = 1;
      default: c_resume = 1;
    endcase
    @(negedge clk);
    c_start = 0; c_stop = 0; c_resume = 0;
  endtask

  task automatic clr_all();
    irq_clr = 3'b111; @(negedge clk); irq_clr = 3'b000;
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] lens [3];
    logic        iocs [3];
    logic        any_ioc;
    void'($urandom(32'd2024));

    wait_cyc(2);
    #1;
    check("R1 active after reset", active, 0);
    check("R1 cur_addr after reset", cur_addr, 0);
    check("R1 status after reset", {status, irq}, 0);
    rst_n = 1;
    @(negedge clk);

    // ring of 4: slots 0..2 owned, slot 3 not owned
    any_ioc = 0;
    for (int s = 0; s < 3; s++) begin
      lens[s] = 16'($urandom_range(1, 16'hFFFF));
      iocs[s] = 1'($urandom_range(0, 1));
      any_ioc |= iocs[s];
      put_desc(s, lens[s], {iocs[s], 6'b0, 1'b1}, 36'(16*(s+1)), 32'h1000 + s, 0);
    end
    put_desc(3, 16'd0, 8'h80, 36'd0, 32'h2000, 0);
    start_addr = 36'd0;
    pulse(0);
    wait_cyc(80);
    check("R3 parks on unowned slot", cur_addr, 36'd48);
    check("R3 stays active when parked", active, 1);
    for (int s = 0; s < 3; s++) begin
      rd(4*s, d);
      check("R6 own bit cleared", d[7:0], {iocs[s], 6'b0, 1'b0});
      rd(4*s+3, d);
      check("R6 actual length written", d, {lens[s], 16'h0003});
    end
    check("R6 done follows ioc", status[0], any_ioc);

    // start while active ignored
    start_addr = 36'd32;
    pulse(0);
    wait_cyc(20);
    check("R2 start while active ignored", cur_addr, 36'd48);

    clr_all();
    check("R11 clear all", status, 3'b000);

    // zero length, owned, no bypass
    put_desc(3, 16'd0, 8'h81, 36'd0, 32'h2000, 0);
    pulse(2);
    wait_cyc(20);
    check("R9 length error set", status, 3'b100);
    check("R9 holds on descriptor", cur_addr, 36'd48);
    rd(12, d);
    check("R9 no write-back", d[0], 1'b1);

    // bypass then resume
    put_desc(3, 16'h1234, 8'h85, 36'd0, 32'h2000, 0);
    pulse(2);
    wait_cyc(30);
    rd(15, d);
    check("R8 bypass actual zero", d[31:16], 16'h0000);
    check("R7 wraps to ring start", cur_addr, 36'd0);
    check("R6 bypass completion done", status[0], 1'b1);
    clr_all();

    // checksum failure
    cs_en = 1;
    put_desc(0, 16'd9, 8'h01, 36'd16, 32'h3000, 1);
    pulse(2);
    wait_cyc(20);
    check("R5 checksum error bit", status, 3'b010);
    check("R5 holds on bad descriptor", cur_addr, 36'd0);
    rd(0, d);
    check("R5 no write-back", d[0], 1'b1);
    cs_en = 0;
    pulse(2);
    wait_cyc(30);
    rd(3, d);
    check("R5 check disabled completes", d[31:16], 16'd9);
    check("R7 advances to next", cur_addr, 36'd16);

    // 36-bit next pointer, aliases to slot 2 (already released)
    put_desc(1, 16'd4, 8'h01, 36'h5_0000_0020, 32'h4000, 0);
    pulse(2);
    wait_cyc(30);
    check("R4 upper next-address bits", cur_addr, 36'h5_0000_0020);

    pulse(1);
    #1;
    check("R10 stop clears active", active, 0);

    // resume while inactive
    put_desc(2, 16'd5, 8'h81, 36'd48, 32'h5000, 0);
    clr_all();
    pulse(2);
    #1;
    check("R12 resume sets active", active, 1);
    wait_cyc(30);
    check("R12 continues from held address", cur_addr, 36'd48);
    rd(11, d);
    check("R12 aliased descriptor processed", d[31:16], 16'd5);

    // mask and partial clear
    irq_en = 3'b000;
    #1 check("R11 masked line low", irq, 0);
    irq_en = 3'b001;
    #1 check("R11 enabled line high", irq, 1);
    irq_clr = 3'b110; @(negedge clk); irq_clr = 3'b000;
    check("R11 unrelated clear keeps bit", status[0], 1'b1);
    clr_all();
    check("R11 line drops after clear", irq, 0);

    // stop mid-transfer
    put_desc(3, 16'd7, 8'h81, 36'd0, 32'h6000, 0);
    pulse(2);
    wait_cyc(6);
    pulse(1);
    #1 check("R10 stop mid-transfer", active, 0);
    wait_cyc(20);
    rd(12, d);
    check("R10 ownership untouched", d[0], 1'b1);
    rd(15, d);
    check("R10 actual untouched", d[31:16], 16'h0000);
    check("R10 no done after stop", status, 3'b000);

    // random single descriptors
    for (int it = 0; it < 16; it++) begin
      logic [15:0] rl;
      logic ri, rb;
      rl = 16'($urandom_range(1, 16'hFFFF));
      ri = 1'($urandom_range(0, 1));
      rb = ($urandom_range(0, 3) == 0);
      pulse(1);
      clr_all();
      put_desc(0, rl, {ri, 4'b0, rb, 2'b01}, 36'd16, $urandom, 0);
      put_desc(1, 16'd1, 8'h00, 36'd0, 32'h0, 0);
      start_addr = 36'd0;
      pulse(0);
      wait_cyc(30);
      check("R7 random next", cur_addr, 36'd16);
      rd(3, d);
      check("R6 random actual", d[31:16], rb ? 16'd0 : rl);
      rd(0, d);
      check("R6 random flags", d[7:0], {ri, 4'b0, rb, 2'b00});
      check("R6 random done", status, {2'b00, ri});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule